// File: doc/BRIEF.md
# Management Command Response Handshake

This block is the hardware side of a single-outstanding management command channel. Software fills one command slot word by word and then writes its verb byte, carrying a command code in the low seven bits and a valid bit in bit 7. The block accepts the command only when that valid bit matches the polarity it currently expects. After a fixed latency it copies the command slot into the active one of two response slots, then swaps the active slot and inverts the expected polarity. Software therefore finds each result by polling the verb byte of the slot it expects next. No separate completion register exists.

The handshake runs as a three-state machine. `ST_IDLE` moves to `ST_FILL` on a start pulse, which clears the command slot. Both `ST_IDLE` and `ST_FILL` move to `ST_BUSY` on an accepted verb write. `ST_BUSY` returns to `ST_IDLE` when the latency count expires, and that transition writes the response. While the block is in `ST_BUSY` it ignores start pulses and command writes. The response body is a copy of the command slot, so what a command means is left to the logic around this block.

Top module: `mgmt_cmd_port`

## Requirements
- R1: After reset, `busy` is 0, `active_slot` is 1, `expect_pol` is 1, and word 0 bits [7:0] (the verb byte) of both response slots read 0. This applies with the default reset value 0 of the command verb valid bit; in general the reset slot is 0 when that bit is 1, and 1 otherwise, and the polarity equals the slot.
- R2: A write to command word 0 with bit 7 equal to `expect_pol` and bits [6:0] nonzero, made while not busy and without a start pulse in the same cycle, raises `busy` on the next cycle. `busy` then stays high for exactly LATENCY cycles.
- R3: A write to word 0 whose bit 7 differs from `expect_pol`, or whose bits [6:0] are zero, starts no command and leaves `busy` low. Its value is still stored in the command slot.
- R4: On completion, the active response slot holds an exact copy of all command words. Its verb byte is therefore {polarity, code} and nonzero.
- R5: On completion, `active_slot` and `expect_pol` both toggle, and they remain equal to each other.
- R6: After a completion, the verb byte of the newly active slot reads 0, and it keeps reading 0 until its own command completes.
- R7: A start pulse while not busy clears every command word to zero, so a later command returns zeros in every word it did not write.
- R8: While busy, start pulses and command writes have no effect, so the response reflects the slot as it stood when the command was accepted.
- R9: Successive commands complete into alternating response slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Begin filling a new command; clears the command slot |
| cmd_we | input | 1 | Command slot word write enable |
| cmd_addr | input | AW | Command word index; index 0 holds the verb byte in bits [7:0] |
| cmd_wdata | input | WORD_W | Command write data |
| rsp_sel | input | 1 | Response slot selected for reading |
| rsp_addr | input | AW | Response word index |
| rsp_rdata | output | WORD_W | Response read data (combinational) |
| busy | output | 1 | High while a command is being processed |
| active_slot | output | 1 | Response slot the next completion will write |
| expect_pol | output | 1 | Valid-bit polarity the next command must carry |

## Verification
An accepted verb write is sampled at the clock edge that follows the write, and `busy` is seen high at the falling edge after that edge. `busy` stays high for LATENCY falling edges. The response contents, the slot swap and the cleared verb byte of the other slot are all visible at the first falling edge at which `busy` is low again. The monitor counts consecutive busy samples and compares the full response only on that falling edge. It reads the combinational response port through short sub-cycle steps, so all of its reads finish before the next rising edge. Rejected verb writes are checked at the falling edges that follow them, and must show `busy` still low there.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_BUSY = 2'd2
    } hs_state_e;

    localparam int VERB_W = 8;
endpackage

// File: rtl/mcr_cmd_slot.sv
module mcr_cmd_slot #(
    parameter int WORD_W     = 32,
    parameter int SLOT_WORDS = 16,
    parameter bit RESET_VB   = 1'b0,
    localparam int AW        = $clog2(SLOT_WORDS)
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  clr_i,
    input  logic                                  we_i,
    input  logic [AW-1:0]                         addr_i,
    input  logic [WORD_W-1:0]                     wdata_i,
    output logic [SLOT_WORDS-1:0][WORD_W-1:0]     words_o
);
    for (genvar g = 0; g < SLOT_WORDS; g++) begin : g_word
        localparam logic [WORD_W-1:0] RST_VAL =
            (g == 0) ? WORD_W'({RESET_VB, 7'b0}) : '0;
        logic [WORD_W-1:0] q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= RST_VAL;
            else if (clr_i)
                q <= '0;
            else if (we_i && (addr_i == AW'(g)))
                q <= wdata_i;
        end
        assign words_o[g] = q;
    end

    // R7
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (words_o == '0));
endmodule

// File: rtl/mcr_rsp_slots.sv
module mcr_rsp_slots #(
    parameter int WORD_W     = 32,
    parameter int SLOT_WORDS = 16,
    localparam int AW        = $clog2(SLOT_WORDS)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en_i,
    input  logic                               wr_sel_i,
    input  logic [SLOT_WORDS-1:0][WORD_W-1:0]  wr_data_i,
    input  logic                               rd_sel_i,
    input  logic [AW-1:0]                      rd_addr_i,
    output logic [WORD_W-1:0]                  rd_data_o
);
    logic [1:0][SLOT_WORDS-1:0][WORD_W-1:0] slots_w;

    for (genvar s = 0; s < 2; s++) begin : g_slot
        logic [SLOT_WORDS-1:0][WORD_W-1:0] q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (wr_en_i) begin
                if (wr_sel_i == 1'(s))
                    q <= wr_data_i;
                else
                    q[0][7:0] <= 8'h00;
            end
        end
        assign slots_w[s] = q;
    end

    assign rd_data_o = slots_w[rd_sel_i][rd_addr_i];

    // R4
    slot_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (slots_w[$past(wr_sel_i)] == $past(wr_data_i)));

    // R4
    verb_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (slots_w[$past(wr_sel_i)][0][7:0] != 8'h00));

    // R6
    other_verb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (slots_w[~$past(wr_sel_i)][0][7:0] == 8'h00));
endmodule

// File: rtl/mcr_hs_fsm.sv
module mcr_hs_fsm
    import mcr_pkg::*;
#(
    parameter int LATENCY  = 5,
    parameter bit RESET_VB = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic verb_we_i,
    input  logic verb_vb_i,
    input  logic verb_code_nz_i,
    output logic busy_o,
    output logic clr_o,
    output logic done_o,
    output logic slot_o,
    output logic pol_o
);
    localparam int CW = $clog2(LATENCY + 1);
    localparam logic [CW-1:0] LAST = CW'(LATENCY - 1);
    localparam logic RESET_IDX = ~RESET_VB;

    hs_state_e      state_q, state_d;
    logic [CW-1:0]  cnt_q;
    logic           slot_q, pol_q;
    logic           fire;

    // Output / decode process
    always_comb begin
        busy_o = (state_q == ST_BUSY);
        clr_o  = start_i && !busy_o;
        fire   = !busy_o && !start_i && verb_we_i &&
                 (verb_vb_i == pol_q) && verb_code_nz_i;
        done_o = busy_o && (cnt_q == LAST);
        slot_o = slot_q;
        pol_o  = pol_q;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_FILL: begin
                if (start_i)
                    state_d = ST_FILL;
                else if (fire)
                    state_d = ST_BUSY;
            end
            ST_BUSY: begin
                if (cnt_q == LAST)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (fire)
            cnt_q <= '0;
        else if (busy_o)
            cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= RESET_IDX;
            pol_q  <= RESET_IDX;
        end else if (done_o) begin
            slot_q <= ~slot_q;
            pol_q  <= ~pol_q;
        end
    end

    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

    // R2
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (cnt_q <= LAST));

    // R3
    mismatch_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && verb_we_i && (verb_vb_i != pol_q)) |=> !busy_o);

    // R8
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o && start_i) |=> (state_q == ST_BUSY));

    // R5
    toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> ((slot_q != $past(slot_q)) && (pol_q != $past(pol_q))));

    // R5
    pol_tracks_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (pol_q == slot_q));
endmodule

// File: rtl/mgmt_cmd_port.sv
module mgmt_cmd_port #(
    parameter int WORD_W       = 32,
    parameter int SLOT_WORDS   = 16,
    parameter int LATENCY      = 5,
    parameter bit CMD_RESET_VB = 1'b0,
    localparam int AW          = $clog2(SLOT_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              cmd_we,
    input  logic [AW-1:0]     cmd_addr,
    input  logic [WORD_W-1:0] cmd_wdata,
    input  logic              rsp_sel,
    input  logic [AW-1:0]     rsp_addr,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic              busy,
    output logic              active_slot,
    output logic              expect_pol
);
    logic                              clr, done, slot, pol, verb_we, wr_ok;
    logic [SLOT_WORDS-1:0][WORD_W-1:0] cmd_words;

    assign verb_we = cmd_we && (cmd_addr == '0);
    assign wr_ok   = cmd_we && !busy;

    mcr_hs_fsm #(
        .LATENCY  (LATENCY),
        .RESET_VB (CMD_RESET_VB)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (cmd_start),
        .verb_we_i      (verb_we),
        .verb_vb_i      (cmd_wdata[7]),
        .verb_code_nz_i (cmd_wdata[6:0] != 7'd0),
        .busy_o         (busy),
        .clr_o          (clr),
        .done_o         (done),
        .slot_o         (slot),
        .pol_o          (pol)
    );

    mcr_cmd_slot #(
        .WORD_W     (WORD_W),
        .SLOT_WORDS (SLOT_WORDS),
        .RESET_VB   (CMD_RESET_VB)
    ) u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr),
        .we_i    (wr_ok),
        .addr_i  (cmd_addr),
        .wdata_i (cmd_wdata),
        .words_o (cmd_words)
    );

    mcr_rsp_slots #(
        .WORD_W     (WORD_W),
        .SLOT_WORDS (SLOT_WORDS)
    ) u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (done),
        .wr_sel_i  (slot),
        .wr_data_i (cmd_words),
        .rd_sel_i  (rsp_sel),
        .rd_addr_i (rsp_addr),
        .rd_data_o (rsp_rdata)
    );

    assign active_slot = slot;
    assign expect_pol  = pol;

    // R4
    cmd_vb_matches_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cmd_words[0][7] == pol));

    // R8
    slot_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cmd_words));
endmodule

// File: tb/test_mgmt_cmd_port.sv
module test_mgmt_cmd_port;
    timeunit 1ns;
    timeprecision 10ps;

    localparam int WW  = 32;
    localparam int SW  = 16;
    localparam int AW  = $clog2(SW);
    localparam int LAT = 5;

    typedef struct packed {
        logic                    slot;
        logic [SW-1:0][WW-1:0]   w;
    } exp_t;

    logic clk = 0, rst_n = 0;
    logic cmd_start = 0, cmd_we = 0;
    logic [AW-1:0] cmd_addr = '0;
    logic [WW-1:0] cmd_wdata = '0;
    logic rsp_sel = 0;
    logic [AW-1:0] rsp_addr = '0;
    logic [WW-1:0] rsp_rdata;
    logic busy, active_slot, expect_pol;

    mgmt_cmd_port #(.WORD_W(WW), .SLOT_WORDS(SW), .LATENCY(LAT)) i_mgmt_cmd_port (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_we(cmd_we),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rsp_sel(rsp_sel),
        .rsp_addr(rsp_addr), .rsp_rdata(rsp_rdata), .busy(busy),
        .active_slot(active_slot), .expect_pol(expect_pol)
    );

    always #4 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    exp_t q_exp[$];
    logic [SW-1:0][WW-1:0] m_words = '0;
    logic m_pol = 1'b1, m_slot = 1'b1, m_busy = 1'b0;
    logic last_slot = 1'b0;
    bit   have_last = 0;
    int   run = 0;

    task automatic chk(input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // Driver: called at a falling edge, returns at the next falling edge
    task automatic wr(input int a, input logic [WW-1:0] d);
        exp_t e;
        bit fired = 0;
        cmd_we = 1; cmd_addr = AW'(a); cmd_wdata = d;
        if (!m_busy) begin
            m_words[a] = d;
            if (a == 0 && d[7] == m_pol && d[6:0] != 7'd0) begin
                e.slot = m_slot; e.w = m_words;
                q_exp.push_back(e);
                m_busy = 1; fired = 1;
                m_slot = ~m_slot; m_pol = ~m_pol;
            end
        end
        @(negedge clk);
        cmd_we = 0;
        if (fired) begin
            // R6: slot being filled still reads a zero verb while busy
            #0.1; rsp_sel = e.slot; rsp_addr = '0; #0.1;
            chk("R6 pending slot verb", {24'h0, rsp_rdata[7:0]}, 32'h0);
            chk("R2 busy after accept", {31'h0, busy}, 32'h1);
        end
    endtask

    task automatic start_cmd();
        cmd_start = 1;
        if (!m_busy) m_words = '0;
        @(negedge clk);
        cmd_start = 0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 100) begin @(negedge clk); guard++; end
        m_busy = 0;
        @(negedge clk);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) run++;
            else if (run != 0) begin
                exp_t e;
                chk("R2 busy length", run, LAT);
                run = 0;
                if (q_exp.size() == 0) begin
                    chk("R4 unexpected completion", 32'h1, 32'h0);
                end else begin
                    e = q_exp.pop_front();
                    for (int w = 0; w < SW; w++) begin
                        rsp_sel = e.slot; rsp_addr = AW'(w); #0.1;
                        chk("R4 response word", rsp_rdata, e.w[w]);
                    end
                    rsp_sel = ~e.slot; rsp_addr = '0; #0.1;
                    chk("R6 other slot verb", {24'h0, rsp_rdata[7:0]}, 32'h0);
                    chk("R5 active slot toggled", {31'h0, active_slot}, {31'h0, ~e.slot});
                    chk("R5 polarity toggled", {31'h0, expect_pol}, {31'h0, ~e.slot});
                    if (have_last)
                        chk("R9 alternation", {31'h0, e.slot}, {31'h0, ~last_slot});
                    last_slot = e.slot; have_last = 1;
                end
            end
        end
    end

    initial begin
        #(8 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1 busy", {31'h0, busy}, 32'h0);
        chk("R1 active slot", {31'h0, active_slot}, 32'h1);
        chk("R1 polarity", {31'h0, expect_pol}, 32'h1);
        rsp_sel = 0; rsp_addr = '0; #0.1;
        chk("R1 slot0 verb", {24'h0, rsp_rdata[7:0]}, 32'h0);
        rsp_sel = 1; #0.1;
        chk("R1 slot1 verb", {24'h0, rsp_rdata[7:0]}, 32'h0);
        @(negedge clk);

        // Basic command (R2, R4, R5)
        start_cmd();
        wr(1, 32'h1111_0001);
        wr(2, 32'hA5A5_5A5A);
        wr(15, 32'hFFFF_0000);
        wr(0, {24'h00CC00, m_pol, 7'h01});
        wait_idle();

        // R3: wrong polarity is rejected but stored
        wr(0, {24'h0, ~m_pol, 7'h05});
        chk("R3 wrong polarity keeps idle", {31'h0, busy}, 32'h0);
        @(negedge clk);
        chk("R3 wrong polarity stays idle", {31'h0, busy}, 32'h0);
        // R3: zero code is rejected
        wr(0, {24'h0, m_pol, 7'h00});
        chk("R3 zero code keeps idle", {31'h0, busy}, 32'h0);
        @(negedge clk);

        // R7 clear on start, R8 ignore while busy
        wr(6, 32'h7777_7777);
        start_cmd();
        wr(5, 32'hDEAD_BEEF);
        wr(0, {24'h0, m_pol, 7'h02});
        start_cmd();                  // R8: ignored
        wr(6, 32'h1234_5678);         // R8: ignored
        wr(0, {24'h0, ~m_pol, 7'h03}); // R8: ignored
        wait_idle();

        // No start: previous words persist (contrast for R7)
        wr(1, 32'h0BAD_F00D);
        wr(0, {24'h0, m_pol, 7'h04});
        wait_idle();

        // R9: run of commands alternating slots
        for (int i = 0; i < 6; i++) begin
            start_cmd();
            wr(2, 32'hC000_0000 + i);
            wr(9, ~(32'h0 + i));
            wr(0, {24'h0, m_pol, 7'(i + 8)});
            wait_idle();
        end

        repeat (3) @(negedge clk);
        chk("R4 all responses seen", q_exp.size(), 32'h0);
        summary();
        $finish;
    end
endmodule